// File: doc/BRIEF.md
# Fixed-Direction GPIO Port with Edge Interrupts

This block is a small GPIO peripheral behind an 8-bit, byte-addressed register bus. It has eight pins. The four low pins are hard-wired outputs and the four high pins are hard-wired inputs. Software writes the output latches and reads the pin levels through a shared data register. A direction register exists only for compatibility: it always reads back the fixed layout, and writes to it change nothing.

Each input pin passes through a two-flop synchroniser. It can then raise an event on a rising edge, a falling edge, or either edge. Each input has its own 2-bit enable field. Events set sticky pending bits, and software clears them by writing ones. A single level interrupt line is high while any pending bit is set.

Top module: `edge_gpio_top`

## Requirements
- R1: A write to offset 1 loads `bus_wdata[3:0]` into the output latches that drive `pin_out`. `bus_wdata[7:4]` is ignored. `pin_out` changes only on such a write.
- R2: A read of offset 1 returns the output latches in bits 3:0. Bits 7:4 hold `pin_in[3:0]` after two synchroniser flops, so a pin change shows up after the second rising clock edge.
- R3: A read of offset 0 always returns 8'h0F. Writes to offset 0 change no register and do not affect `pin_out`.
- R4: Offset 3 is a read/write configuration byte. Input n (n = 0..3, which is `pin_in[n]`) owns bits [2n+1:2n]. Bit 2n enables falling-edge detection and bit 2n+1 enables rising-edge detection.
- R5: With rising detection enabled, a 0-to-1 change on an input sets pending bit n. The bit is set, and `irq` goes high, after the third rising clock edge following the change. A falling edge alone does not set it.
- R6: With only falling detection enabled, a 1-to-0 change sets pending bit n and a 0-to-1 change does not.
- R7: Field value 11 detects both edges. Field value 00 masks the input, so no edge sets its pending bit.
- R8: Offset 4 returns the pending bits in bits 3:0 and zero in bits 7:4. A write to offset 4 clears each pending bit whose `bus_wdata` bit is 1 and leaves the other pending bits unchanged.
- R9: If an enabled edge on input n is detected in the same cycle as a clearing write to pending bit n, the bit stays set.
- R10: `irq` is high exactly while at least one pending bit is set. It stays high until the last pending bit is cleared.
- R11: While `rst_n` is low, the output latches, the configuration byte and the pending bits are cleared, and `irq` is low.
- R12: Reads of offsets 2, 5, 6 and 7 return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, committed on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_out | output | 4 | Output pins 0..3 |
| pin_in | input | 4 | Asynchronous input pins 4..7 |
| irq | output | 1 | Level interrupt, OR of the pending bits |

## Verification
The bench checks edge selection in each direction separately. A design that swapped the falling and rising bits of a field would flag the wrong edge of a single-edge input, and a masked input that still reacts would set a pending bit with its field at 00. The write-one-to-clear path is checked with two bits pending and only one cleared, which catches a clear that wipes the whole register or one that drops `irq` while a bit remains. The bench also times a clearing write so that it lands exactly in the cycle an edge is detected: a design where the clear wins would lose that event. Finally, the interrupt is sampled one cycle before and at its expected rising point, which catches a synchroniser that is one flop too short or too long.

// File: rtl/edge_gpio_pkg.sv
package edge_gpio_pkg;
  localparam int N_OUT = 4;
  localparam int N_IN = 4;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int CFG_W = 2 * N_IN;
  localparam int CFG_FALL = 0;
  localparam int CFG_RISE = 1;

  localparam logic [AW-1:0] OFS_DIR  = 3'd0;
  localparam logic [AW-1:0] OFS_DATA = 3'd1;
  localparam logic [AW-1:0] OFS_ECFG = 3'd3;
  localparam logic [AW-1:0] OFS_PEND = 3'd4;

  // fixed direction image: ones for the output pins
  localparam logic [DW-1:0] DIR_IMAGE = DW'((1 << N_OUT) - 1);

  function automatic logic [1:0] cfg_field(input logic [CFG_W-1:0] cfg, input int idx);
    return cfg[2*idx +: 2];
  endfunction

  function automatic logic edge_hit(input logic [1:0] fld, input logic cur, input logic prv);
    return (fld[CFG_FALL] & prv & ~cur) | (fld[CFG_RISE] & cur & ~prv);
  endfunction
endpackage

// File: rtl/edge_gpio_sync.sv
module edge_gpio_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_gpio_detect.sv
module edge_gpio_detect
  import edge_gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  lvl_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [N_IN-1:0]  evt_o
);
  logic [N_IN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_hit
    assign evt_o[g] = edge_hit(cfg_field(cfg_i, g), lvl_i[g], prev_q[g]);
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i == '0) |-> (evt_o == '0)); // R7
endmodule

// File: rtl/edge_gpio_pend.sv
module edge_gpio_pend
  import edge_gpio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] evt_i,
  input  logic [N_IN-1:0] clr_i,
  output logic [N_IN-1:0] pend_o
);
  logic [N_IN-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | evt_i;
  end

  assign pend_o = pend_q;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_q & $past(clr_i & ~evt_i)) == '0)); // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i == '0) && (evt_i == '0)) |=> $stable(pend_q)); // R8
endmodule

// File: rtl/edge_gpio_top.sv
module edge_gpio_top
  import edge_gpio_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [N_OUT-1:0] pin_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic           irq
);
  logic [N_OUT-1:0] out_q;
  logic [CFG_W-1:0] cfg_q;
  logic [N_IN-1:0]  lvl_sync;
  logic [N_IN-1:0]  edge_evt;
  logic [N_IN-1:0]  pend_bits;
  logic [N_IN-1:0]  clr_req;
  logic             wr_data, wr_cfg, wr_pend;
  logic             evt_any;

  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_cfg  = bus_wr && (bus_addr == OFS_ECFG);
  assign wr_pend = bus_wr && (bus_addr == OFS_PEND);
  assign clr_req = wr_pend ? bus_wdata[N_IN-1:0] : '0;
  assign evt_any = |edge_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_data) out_q <= bus_wdata[N_OUT-1:0];
      if (wr_cfg)  cfg_q <= bus_wdata[CFG_W-1:0];
    end
  end

  edge_gpio_sync #(.W(N_IN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(lvl_sync));

  edge_gpio_detect u_detect (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync), .cfg_i(cfg_q), .evt_o(edge_evt));

  edge_gpio_pend u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(edge_evt), .clr_i(clr_req), .pend_o(pend_bits));

  always_comb begin
    case (bus_addr)
      OFS_DIR:  bus_rdata = DIR_IMAGE;
      OFS_DATA: bus_rdata = {lvl_sync, out_q};
      OFS_ECFG: bus_rdata = cfg_q;
      OFS_PEND: bus_rdata = DW'(pend_bits);
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign irq = |pend_bits;

  AST_PINOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(pin_out)); // R1
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt_any)); // R10
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_pend)); // R8
endmodule

// File: tb/edge_gpio_top_tb_top.sv
module edge_gpio_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] pin_out;
  logic [3:0] pin_in = '0;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  edge_gpio_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_in(pin_in), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // change pins, then settle past the detection point
  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R11 pin_out", {4'h0, pin_out}, 8'h00);
    check("R11 irq", {7'h0, irq}, 8'h00);
    bus_read(3'd3, d); check("R11 cfg", d, 8'h00);
    bus_read(3'd4, d); check("R11 pend", d, 8'h00);
  endtask

  task automatic t_data_out();
    logic [7:0] d;
    bus_write(3'd1, 8'hA5);
    check("R1 pin_out", {4'h0, pin_out}, 8'h05);
    bus_read(3'd1, d); check("R2 data low", {4'h0, d[3:0]}, 8'h05);
    bus_write(3'd1, 8'h0A);
    check("R1 pin_out 2", {4'h0, pin_out}, 8'h0A);
  endtask

  task automatic t_dir();
    logic [7:0] d;
    bus_read(3'd0, d); check("R3 dir", d, 8'h0F);
    bus_write(3'd0, 8'hF0);
    bus_read(3'd0, d); check("R3 dir after write", d, 8'h0F);
    check("R3 pin_out kept", {4'h0, pin_out}, 8'h0A);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    bus_write(3'd2, 8'hFF);
    bus_read(3'd2, d); check("R12 ofs2", d, 8'h00);
    bus_read(3'd5, d); check("R12 ofs5", d, 8'h00);
    bus_read(3'd6, d); check("R12 ofs6", d, 8'h00);
    bus_read(3'd7, d); check("R12 ofs7", d, 8'h00);
  endtask

  task automatic t_input_read();
    logic [7:0] d;
    @(negedge clk);
    pin_in = 4'b1001;
    @(posedge clk); @(negedge clk);
    bus_read(3'd1, d); check("R2 one flop not yet", {4'h0, d[7:4]}, 8'h00);
    @(posedge clk); @(negedge clk);
    bus_read(3'd1, d); check("R2 input nibble", {4'h0, d[7:4]}, 8'h09);
    set_pins(4'b0000);
  endtask

  task automatic t_cfg_masked();
    logic [7:0] d;
    bus_write(3'd3, 8'hC6);
    bus_read(3'd3, d); check("R4 cfg readback", d, 8'hC6);
    bus_write(3'd3, 8'h00);
    set_pins(4'b1111);
    set_pins(4'b0000);
    bus_read(3'd4, d); check("R7 masked pend", d, 8'h00);
    check("R7 masked irq", {7'h0, irq}, 8'h00);
  endtask

  task automatic t_rise();
    logic [7:0] d;
    bus_write(3'd3, 8'h02);          // input 0 rising only
    @(negedge clk);
    pin_in = 4'b0001;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R5 irq early", {7'h0, irq}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R5 irq at third edge", {7'h0, irq}, 8'h01);
    bus_read(3'd4, d); check("R5 pend", d, 8'h01);
    bus_write(3'd4, 8'h01);
    check("R10 irq cleared", {7'h0, irq}, 8'h00);
    set_pins(4'b0000);
    bus_read(3'd4, d); check("R5 fall ignored", d, 8'h00);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    bus_write(3'd3, 8'h04);          // input 1 falling only
    set_pins(4'b0010);
    bus_read(3'd4, d); check("R6 rise ignored", d, 8'h00);
    set_pins(4'b0000);
    bus_read(3'd4, d); check("R6 fall sets", d, 8'h02);
    bus_write(3'd4, 8'h02);
  endtask

  task automatic t_both();
    logic [7:0] d;
    bus_write(3'd3, 8'h30);          // input 2 both edges
    set_pins(4'b0100);
    bus_read(3'd4, d); check("R7 both rise", d, 8'h04);
    bus_write(3'd4, 8'h04);
    set_pins(4'b0000);
    bus_read(3'd4, d); check("R7 both fall", d, 8'h04);
    bus_write(3'd4, 8'h04);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    bus_write(3'd3, 8'h32);          // input 0 rise, input 2 both
    set_pins(4'b0101);
    bus_read(3'd4, d); check("R8 two pending", d, 8'h05);
    bus_write(3'd4, 8'h01);
    bus_read(3'd4, d); check("R8 partial clear", d, 8'h04);
    check("R10 irq held", {7'h0, irq}, 8'h01);
    bus_write(3'd4, 8'h04);
    check("R10 irq drops", {7'h0, irq}, 8'h00);
    set_pins(4'b0000);
    bus_write(3'd4, 8'h0F);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    bus_write(3'd3, 8'h02);          // input 0 rising
    set_pins(4'b0001);               // pend bit 0 now set
    set_pins(4'b0000);
    @(negedge clk);
    pin_in = 4'b0001;
    repeat (2) @(posedge clk);
    @(negedge clk);                  // edge detected during next cycle
    bus_addr = 3'd4; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(3'd4, d); check("R9 event beats clear", d, 8'h01);
    check("R9 irq", {7'h0, irq}, 8'h01);
    bus_write(3'd4, 8'h01);
    bus_read(3'd4, d); check("R8 clear after", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_out();
    t_dir();
    t_unused();
    t_input_read();
    t_cfg_masked();
    t_rise();
    t_fall();
    t_both();
    t_w1c();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule